// File: doc/BRIEF.md
# Playback Channel Sample Buffer

This block is the per-channel playback buffer of a frame-based serial audio link. The host side pushes 32-bit words, each packing two 16-bit PCM samples. The link side pulls one 20-bit slot value per frame by pulsing a request. Each stored word is split into two slots. The lower half is played first, and every sample is left-justified into 20 bits with four zero bits below it.

The buffer compares its free space against a refill level, which defaults to the full depth. When the free space first reaches that level, the block raises a DMA request. The requester answers with a burst of exactly that many word writes and then pulses an acknowledge. The block also keeps three sticky status bits: refill level reached, underrun and overrun. A neighbouring interrupt unit decodes these bits and clears them with a one-cycle clear pulse.

Top module: `pcm_play_chan`

## Requirements
- R1: Each stored word gives two slots in sequence: bits [15:0] first, then bits [31:16]. The word leaves the buffer after its upper half has been played.
- R2: A slot value is the 16-bit sample in bits [19:4], with bits [3:0] equal to zero.
- R3: `dma_req` rises one clock after the edge at which the free space first becomes at least REFILL words (REFILL = DEPTH by default). This includes the first edge after reset, when the buffer is empty.
- R4: `dma_req` is low from the edge at which `dma_ack` is sampled high. It stays low until the free space has dropped below REFILL and then reached it again.
- R5: `status` bit 0 means refill level reached, bit 1 means underrun and bit 2 means overrun. Bit 0 is set by the same event that raises `dma_req`.
- R6: A slot request while the buffer is empty is an underrun. It sets `status` bit 1 and loads zero into `slot_data`.
- R7: A write while the buffer holds DEPTH words is an overrun. It sets `status` bit 2 and drops the word, leaving the stored words and their order unchanged.
- R8: Status bits are sticky until a `status_clr` pulse. When a clear and a new event fall on the same edge, the new event's bit ends up set.
- R9: Reset (asynchronous, active low) empties the buffer, clears `status`, `dma_req` and `slot_data`, and points the next slot back at the low half of a word.
- R10: A write and a word-consuming slot request on the same edge both take effect, and the fill level is unchanged.
- R11: `slot_data` is registered. It updates on the edge that samples `slot_req` and holds its value at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host word write strobe |
| wr_data | input | 32 | Host word: two 16-bit samples |
| slot_req | input | 1 | Link side requests the next slot |
| slot_data | output | 20 | Left-justified slot value |
| dma_req | output | 1 | Refill request |
| dma_ack | input | 1 | One-cycle pulse closing a refill burst |
| status_clr | input | 1 | One-cycle clear of all status bits |
| status | output | 3 | {overrun, underrun, refill level reached} |

## Verification
Every result appears one edge after the stimulus that causes it. A slot request, a write that overflows and a status clear all act at the next rising edge. The free-space comparison adds a second edge, so `dma_req` and the level bit rise one clock after the edge that changed the fill level. The bench drives inputs on the falling edge and samples on the following falling edge. Each table row therefore holds the outputs due after exactly one rising edge, and the two-edge refill timing is written into the expected column of the row after the fill change.

// File: rtl/pcm_play_pkg.sv
package pcm_play_pkg;
  localparam int SAMPLE_W = 16;
  localparam int SLOT_W   = 20;
  localparam int WORD_W   = 2 * SAMPLE_W;
  localparam int STAT_W   = 3;
  localparam int ST_LEVEL = 0;
  localparam int ST_UNDER = 1;
  localparam int ST_OVER  = 2;

  function automatic logic [SLOT_W-1:0] to_slot(input logic [SAMPLE_W-1:0] s);
    return {s, {(SLOT_W - SAMPLE_W){1'b0}}};
  endfunction
endpackage

// File: rtl/pcm_play_store.sv
module pcm_play_store #(
  parameter int DEPTH  = 4,
  parameter int WORD_W = 32,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] head,
  output logic [CNT_W-1:0]  fill
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CNT_W-1:0]  fill_q, fill_d;

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    fill_d = fill_q;
    if (push) wptr_d = (wptr_q == PTR_W'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
    if (pop)  rptr_d = (rptr_q == PTR_W'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
    if (push && !pop)      fill_d = fill_q + 1'b1;
    else if (pop && !push) fill_d = fill_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      fill_q <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      fill_q <= fill_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wptr_q] <= wdata;
  end

  assign head = mem[rptr_q];
  assign fill = fill_q;
endmodule

// File: rtl/pcm_play_unpack.sv
module pcm_play_unpack
  import pcm_play_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_req,
  input  logic              empty,
  input  logic [WORD_W-1:0] head,
  output logic              pop,
  output logic              underrun,
  output logic [SLOT_W-1:0] slot_data
);
  logic              hi_q, hi_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [SAMPLE_W-1:0] pick;

  always_comb begin
    pick     = hi_q ? head[WORD_W-1:SAMPLE_W] : head[SAMPLE_W-1:0];
    underrun = slot_req && empty;
    pop      = slot_req && !empty && hi_q;
    hi_d     = hi_q;
    slot_d   = slot_q;
    if (slot_req) begin
      if (empty) begin
        slot_d = '0;
      end else begin
        slot_d = to_slot(pick);
        hi_d   = !hi_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= 1'b0;
      slot_q <= '0;
    end else begin
      hi_q   <= hi_d;
      slot_q <= slot_d;
    end
  end

  assign slot_data = slot_q;
endmodule

// File: rtl/pcm_play_refill.sv
module pcm_play_refill
  import pcm_play_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int REFILL = DEPTH,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  fill,
  input  logic              dma_ack,
  input  logic              status_clr,
  input  logic              underrun,
  input  logic              overrun,
  output logic              dma_req,
  output logic [STAT_W-1:0] status
);
  localparam logic [CNT_W-1:0] DEPTH_C  = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] REFILL_C = CNT_W'(REFILL);

  logic              lvl_q, lvl_d;
  logic              req_q, req_d;
  logic [STAT_W-1:0] st_q, st_d, ev;
  logic              lvl_rise;

  always_comb begin
    lvl_d    = (DEPTH_C - fill) >= REFILL_C;
    lvl_rise = lvl_d && !lvl_q;
    req_d    = dma_ack ? 1'b0 : (req_q || lvl_rise);
    ev           = '0;
    ev[ST_LEVEL] = lvl_rise;
    ev[ST_UNDER] = underrun;
    ev[ST_OVER]  = overrun;
    st_d = (status_clr ? '0 : st_q) | ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      req_q <= 1'b0;
      st_q  <= '0;
    end else begin
      lvl_q <= lvl_d;
      req_q <= req_d;
      st_q  <= st_d;
    end
  end

  assign dma_req = req_q;
  assign status  = st_q;
endmodule

// File: rtl/pcm_play_chan.sv
module pcm_play_chan
  import pcm_play_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int REFILL = DEPTH,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  input  logic              slot_req,
  output logic [19:0]       slot_data,
  output logic              dma_req,
  input  logic              dma_ack,
  input  logic              status_clr,
  output logic [2:0]        status
);
  logic [CNT_W-1:0]  fill;
  logic [WORD_W-1:0] head;
  logic full, empty, push, pop, underrun, overrun;

  assign full    = (fill == CNT_W'(DEPTH));
  assign empty   = (fill == '0);
  assign push    = wr_en && !full;
  assign overrun = wr_en && full;

  pcm_play_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_store (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
    .wdata(wr_data), .head(head), .fill(fill)
  );

  pcm_play_unpack u_unpack (
    .clk(clk), .rst_n(rst_n), .slot_req(slot_req), .empty(empty),
    .head(head), .pop(pop), .underrun(underrun), .slot_data(slot_data)
  );

  pcm_play_refill #(.DEPTH(DEPTH), .REFILL(REFILL)) u_refill (
    .clk(clk), .rst_n(rst_n), .fill(fill), .dma_ack(dma_ack),
    .status_clr(status_clr), .underrun(underrun), .overrun(overrun),
    .dma_req(dma_req), .status(status)
  );
endmodule

// File: rtl/pcm_play_chan_chk.sv
module pcm_play_chan_chk #(
  parameter int DEPTH  = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             slot_req,
  input logic             dma_ack,
  input logic             status_clr,
  input logic             dma_req,
  input logic [2:0]       status,
  input logic [19:0]      slot_data,
  input logic [CNT_W-1:0] fill
);
  p_ack_drops_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dma_ack |=> !dma_req);

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !status_clr |=> ((status | $past(status)) == status));

  p_underrun_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_req && fill == '0) |=> (slot_data == '0 && status[1]));

  p_overrun_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !slot_req && fill == CNT_W'(DEPTH)) |=> (status[2] && fill == $past(fill)));

  p_slot_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_req |=> $stable(slot_data));

  p_slot_pad_r2: assert property (@(posedge clk) disable iff (!rst_n)
    slot_data[3:0] == 4'b0);

  p_level_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CNT_W'(DEPTH));
endmodule

bind pcm_play_chan pcm_play_chan_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .slot_req(slot_req),
  .dma_ack(dma_ack), .status_clr(status_clr), .dma_req(dma_req),
  .status(status), .slot_data(slot_data), .fill(fill)
);

// File: tb/tb_pcm_play_chan.sv
module tb_pcm_play_chan;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, slot_req, dma_ack, status_clr;
  logic [31:0] wr_data;
  logic [19:0] slot_data;
  logic        dma_req;
  logic [2:0]  status;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pcm_play_chan dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .slot_req(slot_req), .slot_data(slot_data), .dma_req(dma_req),
    .dma_ack(dma_ack), .status_clr(status_clr), .status(status)
  );

  typedef struct packed {
    logic        wr;
    logic [31:0] data;
    logic        sreq;
    logic        ack;
    logic        clr;
    logic [19:0] e_slot;
    logic        e_req;
    logic [2:0]  e_st;
  } vec_t;

  localparam int NV = 25;
  // Expected outputs are those seen one rising edge after the row's inputs.
  localparam vec_t VEC [NV] = '{
    '{1'b0, 32'h0,         1'b0, 1'b0, 1'b0, 20'h00000, 1'b1, 3'b001}, // R3 R5 first edge after reset
    '{1'b0, 32'h0,         1'b0, 1'b0, 1'b1, 20'h00000, 1'b1, 3'b000}, // R8 clear
    '{1'b1, 32'hBBBB_AAAA, 1'b0, 1'b0, 1'b0, 20'h00000, 1'b1, 3'b000},
    '{1'b1, 32'hDDDD_CCCC, 1'b0, 1'b0, 1'b0, 20'h00000, 1'b1, 3'b000},
    '{1'b1, 32'h2222_1111, 1'b0, 1'b0, 1'b0, 20'h00000, 1'b1, 3'b000},
    '{1'b1, 32'h4444_3333, 1'b0, 1'b1, 1'b0, 20'h00000, 1'b0, 3'b000}, // R4 ack ends burst
    '{1'b1, 32'h9999_8888, 1'b0, 1'b0, 1'b0, 20'h00000, 1'b0, 3'b100}, // R7 overrun
    '{1'b0, 32'h0,         1'b1, 1'b0, 1'b0, 20'hAAAA0, 1'b0, 3'b100}, // R1 R2 low half first
    '{1'b0, 32'h0,         1'b1, 1'b0, 1'b0, 20'hBBBB0, 1'b0, 3'b100},
    '{1'b0, 32'h0,         1'b1, 1'b0, 1'b1, 20'hCCCC0, 1'b0, 3'b000},
    '{1'b0, 32'h0,         1'b1, 1'b0, 1'b0, 20'hDDDD0, 1'b0, 3'b000},
    '{1'b0, 32'h0,         1'b1, 1'b0, 1'b0, 20'h11110, 1'b0, 3'b000},
    '{1'b0, 32'h0,         1'b1, 1'b0, 1'b0, 20'h22220, 1'b0, 3'b000},
    '{1'b0, 32'h0,         1'b1, 1'b0, 1'b0, 20'h33330, 1'b0, 3'b000},
    '{1'b0, 32'h0,         1'b1, 1'b0, 1'b0, 20'h44440, 1'b0, 3'b000}, // R7 dropped word absent
    '{1'b0, 32'h0,         1'b1, 1'b0, 1'b0, 20'h00000, 1'b1, 3'b011}, // R6 underrun, R3 refill
    '{1'b0, 32'h0,         1'b0, 1'b1, 1'b1, 20'h00000, 1'b0, 3'b000}, // R4 ack
    '{1'b0, 32'h0,         1'b0, 1'b0, 1'b0, 20'h00000, 1'b0, 3'b000}, // R4 no re-raise, R11 hold
    '{1'b1, 32'h1234_5678, 1'b0, 1'b0, 1'b0, 20'h00000, 1'b0, 3'b000},
    '{1'b0, 32'h0,         1'b1, 1'b0, 1'b0, 20'h56780, 1'b0, 3'b000},
    '{1'b1, 32'hCAFE_F00D, 1'b1, 1'b0, 1'b0, 20'h12340, 1'b0, 3'b000}, // R10 push and pop
    '{1'b0, 32'h0,         1'b1, 1'b0, 1'b0, 20'hF00D0, 1'b0, 3'b000},
    '{1'b0, 32'h0,         1'b1, 1'b0, 1'b0, 20'hCAFE0, 1'b0, 3'b000},
    '{1'b0, 32'h0,         1'b0, 1'b0, 1'b0, 20'hCAFE0, 1'b1, 3'b001}, // R3 R11
    '{1'b0, 32'h0,         1'b1, 1'b0, 1'b1, 20'h00000, 1'b1, 3'b010}  // R8 event beats clear
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic w, input logic [31:0] d, input logic s,
                       input logic a, input logic c);
    wr_en = w; wr_data = d; slot_req = s; dma_ack = a; status_clr = c;
    @(negedge clk);
    wr_en = 1'b0; slot_req = 1'b0; dma_ack = 1'b0; status_clr = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0;
    wr_en = 1'b0; wr_data = '0; slot_req = 1'b0; dma_ack = 1'b0; status_clr = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 reset slot", 32'(slot_data), 32'h0);
    check("R9 reset dma_req", 32'(dma_req), 32'h0);
    check("R9 reset status", 32'(status), 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].wr, VEC[i].data, VEC[i].sreq, VEC[i].ack, VEC[i].clr);
      check($sformatf("R1 R2 R6 R10 R11 slot row %0d", i), 32'(slot_data), 32'(VEC[i].e_slot));
      check($sformatf("R3 R4 dma_req row %0d", i), 32'(dma_req), 32'(VEC[i].e_req));
      check($sformatf("R5 R7 R8 status row %0d", i), 32'(status), 32'(VEC[i].e_st));
    end

    // R9: reset in mid-word returns to the low half of a fresh word
    drive(1'b1, 32'h7777_6666, 1'b0, 1'b0, 1'b0);
    drive(1'b0, 32'h0, 1'b1, 1'b0, 1'b0);
    check("R9 pre-reset slot", 32'(slot_data), 32'h66660);
    #2 rst_n = 1'b0;
    #2;
    check("R9 async slot", 32'(slot_data), 32'h0);
    check("R9 async dma_req", 32'(dma_req), 32'h0);
    check("R9 async status", 32'(status), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    drive(1'b1, 32'h5555_4444, 1'b0, 1'b0, 1'b0);
    check("R9 R3 req after reset", 32'(dma_req), 32'h1);
    drive(1'b0, 32'h0, 1'b1, 1'b0, 1'b0);
    check("R9 half pointer low", 32'(slot_data), 32'h44440);
    drive(1'b0, 32'h0, 1'b1, 1'b0, 1'b0);
    check("R9 old word gone", 32'(slot_data), 32'h55550);
    drive(1'b0, 32'h0, 1'b1, 1'b0, 1'b0);
    check("R9 R6 empty after", 32'(slot_data), 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule